// File: doc/BRIEF.md
# Low-Order Interleaved Memory Controller

This block spreads word addresses across `NUM_BANKS` independent memory banks. The lowest address bits pick the bank, so consecutive words land in different banks. Every bank takes a fixed `NUM_BANKS` cycles to serve an access. Because the bank count equals that access time, a stream of consecutive addresses keeps every bank busy in turn. After the first result, the controller delivers one word per cycle.

Requests arrive one per cycle on a valid/ready handshake. When a request is accepted, its target bank copies the word address, the write data and the operation into its own registers, then counts down its latency. Other banks keep working in parallel. A request to a bank that has not finished holds `req_ready` low until that bank can take it.

Read results come back with a one-cycle valid strobe, in the order the reads were issued. A shift queue that is `NUM_BANKS+1` entries deep tracks them and picks which bank's data register drives the response.

Each bank runs a two-state machine:
- `BK_IDLE`: no access in flight. It moves to `BK_BUSY` when it accepts a request.
- `BK_BUSY`: counts down from `NUM_BANKS-1`. While the count is non-zero it stays in `BK_BUSY`.
- When the count reaches zero, the bank finishes its access on the next edge. At that edge it either returns to `BK_IDLE`, or it reloads and stays in `BK_BUSY` if it accepts a new request in the same cycle.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `req_ready` is 1 and `rsp_valid` is 0. Reads in flight when reset is asserted never produce a response.
- R2: The bank is `req_addr[log2(NUM_BANKS)-1:0]` and the word within the bank is the remaining upper address bits. Every address has its own storage.
- R3: If a request to bank b is accepted at clock edge k, any request to bank b sees `req_ready` = 0 before edges k+1 through k+NUM_BANKS-1. A request held on the interface is accepted at edge k+NUM_BANKS.
- R4: A request to a bank with no access pending is accepted at once, whatever the other banks are doing.
- R5: A read accepted at edge k gives `rsp_valid` = 1 for exactly the cycle after edge k+NUM_BANKS, with the addressed word on `rsp_rdata`.
- R6: A write never produces a response.
- R7: Responses come out in the order the reads were accepted, exactly one per read.
- R8: A stream of consecutive addresses is accepted one per cycle with no stall. Its results emerge one per cycle, starting NUM_BANKS cycles after the first request.
- R9: A read to an address that was just written returns the new data, even when the read is accepted at the earliest edge that R3 allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read result present this cycle |
| rsp_rdata | output | DATA_W | Read result |

## Verification
The bench targets three cases:
- Same-bank collisions with a request held waiting. A bank whose ready came one cycle late or early would break the exact stall pattern that is checked on every cycle.
- A consecutive-address read burst. A controller that left a bank blocked in its finishing cycle would stall once per wrap and move responses off the predicted cycle.
- A read issued at the first legal edge after a write to the same word, plus a reset in the middle of a read. A bank that overwrote its registers before finishing would return stale data, and a tracker that kept its entries through reset would emit a response that no read is waiting for.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_BUSY = 1'b1
    } bank_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int WORDS   = 64,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 4,
    localparam int AW     = $clog2(WORDS),
    localparam int CNT_W  = $clog2(LATENCY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              acc_we,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              can_take,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LATENCY - 1);

    bank_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              finishing;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] mem [WORDS];

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_IDLE: begin
                if (acc) begin
                    state_d = BK_BUSY;
                    cnt_d   = LOAD;
                end
            end
            BK_BUSY: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (acc) begin
                    cnt_d = LOAD;
                end else begin
                    state_d = BK_IDLE;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        finishing = (state_q == BK_BUSY) && (cnt_q == '0);
        can_take  = (state_q == BK_IDLE) || finishing;
    end

    // access registers: hold this bank's request while others proceed
    always_ff @(posedge clk) begin
        if (acc) begin
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
            we_q    <= acc_we;
        end
    end

    // storage array, touched only when the countdown expires
    always_ff @(posedge clk) begin
        if (finishing) begin
            if (we_q) begin
                mem[addr_q] <= wdata_q;
            end else begin
                rdata_q <= mem[addr_q];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ilv_order_track.sv
module ilv_order_track #(
    parameter int DEPTH = 5,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag
);
    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q[0] <= 1'b0;
        end else begin
            vld_q[0] <= push;
        end
        tag_q[0] <= push_tag;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[s] <= 1'b0;
            end else begin
                vld_q[s] <= vld_q[s-1];
            end
            tag_q[s] <= tag_q[s-1];
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_tag   = tag_q[DEPTH-1];
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int BSEL_W    = $clog2(NUM_BANKS);
    localparam int IN_W      = ADDR_W - BSEL_W;
    localparam int BANK_WDS  = 1 << IN_W;
    localparam int TRK_DEPTH = NUM_BANKS + 1;

    logic [BSEL_W-1:0] bank_sel;
    logic [IN_W-1:0]   in_addr;
    logic              accept;
    logic              take [NUM_BANKS];
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
    logic [BSEL_W-1:0] trk_bank;
    logic              trk_valid;

    assign bank_sel  = req_addr[BSEL_W-1:0];
    assign in_addr   = req_addr[ADDR_W-1:BSEL_W];
    assign req_ready = take[bank_sel];
    assign accept    = req_valid && req_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .WORDS   (BANK_WDS),
            .DATA_W  (DATA_W),
            .LATENCY (NUM_BANKS)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .acc       (accept && (bank_sel == BSEL_W'(b))),
            .acc_we    (req_write),
            .acc_addr  (in_addr),
            .acc_wdata (req_wdata),
            .can_take  (take[b]),
            .rdata     (bank_rdata[b])
        );
    end

    ilv_order_track #(
        .DEPTH (TRK_DEPTH),
        .TAG_W (BSEL_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .push      (accept && !req_write),
        .push_tag  (bank_sel),
        .out_valid (trk_valid),
        .out_tag   (trk_bank)
    );

    assign rsp_valid = trk_valid;
    assign rsp_rdata = bank_rdata[trk_bank];
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16,
    localparam int BSEL_W   = $clog2(NUM_BANKS),
    localparam int GAP_W    = $clog2(NUM_BANKS + 1),
    localparam int OUT_W    = $clog2(NUM_BANKS + 3)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [BSEL_W-1:0] req_bank,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata
);
    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(NUM_BANKS);

    logic [GAP_W-1:0] gap [NUM_BANKS];
    logic [OUT_W-1:0] rd_out;
    logic             acc;

    assign acc = req_valid && req_ready;

    // edges since the last accept per bank, saturating at NUM_BANKS
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rst) begin
                gap[b] <= GAP_FULL;
            end else if (acc && req_bank == BSEL_W'(b)) begin
                gap[b] <= GAP_W'(1);
            end else if (gap[b] != GAP_FULL) begin
                gap[b] <= gap[b] + 1'b1;
            end
        end
    end

    // reads accepted but not yet answered
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out <= '0;
        end else begin
            rd_out <= rd_out + OUT_W'(acc && !req_write) - OUT_W'(rsp_valid);
        end
    end

    // R1: a fresh reset leaves the interface ready and silent
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid));

    // R3: ready follows the per-bank spacing of NUM_BANKS cycles
    a_r3_ready_matches_spacing: assert property (@(posedge clk) disable iff (rst)
        req_ready == (gap[req_bank] == GAP_FULL));

    // R7: every response is owed to an earlier read
    a_r7_rsp_has_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rd_out != '0));

    // R7: never more reads outstanding than the pipeline can hold
    a_r7_outstanding_bound: assert property (@(posedge clk) disable iff (rst)
        rd_out <= OUT_W'(NUM_BANKS + 1));

    // R5: response data is driven when flagged
    a_r5_rsp_data_known: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !$isunknown(rsp_rdata));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_bank  (req_addr[$clog2(NUM_BANKS)-1:0]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/ilv_mem_ctrl_test.sv
module ilv_mem_ctrl_test;
    localparam int M  = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int rsp_count = 0;
    logic [DW-1:0] last_rsp = '0;
    logic [DW-1:0] model [1 << AW];
    int last_acc [M];
    logic [DW-1:0] exp_data_q [$];
    int            exp_cyc_q  [$];

    // {write, addr, wdata}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h00, 16'hA000}, {1'b1, 8'h01, 16'hA001},
        {1'b1, 8'h02, 16'hA002}, {1'b1, 8'h03, 16'hA003},
        {1'b1, 8'h04, 16'hA004}, {1'b1, 8'h08, 16'hA008},
        {1'b1, 8'h0C, 16'hA00C}, {1'b0, 8'h00, 16'h0000},
        {1'b0, 8'h04, 16'h0000}, {1'b0, 8'h01, 16'h0000},
        {1'b0, 8'h08, 16'h0000}, {1'b0, 8'h02, 16'h0000},
        {1'b0, 8'h0C, 16'h0000}, {1'b0, 8'h03, 16'h0000},
        {1'b1, 8'hFF, 16'h5A5A}, {1'b1, 8'hFE, 16'hA5A5},
        {1'b0, 8'hFF, 16'h0000}, {1'b0, 8'hFE, 16'h0000},
        {1'b1, 8'h05, 16'h0F0F}, {1'b0, 8'h05, 16'h0000}
    };

    ilv_mem_ctrl #(.NUM_BANKS(M), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk, .rst, .req_valid, .req_ready, .req_write,
        .req_addr, .req_wdata, .rsp_valid, .rsp_rdata
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // response monitor: data, cycle and order against the issue record
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            rsp_count++;
            last_rsp = rsp_rdata;
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R6 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
            end else begin
                check(rsp_rdata == exp_data_q[0], "R2/R7 read data",
                      32'(rsp_rdata), 32'(exp_data_q[0]));
                check(cyc == exp_cyc_q[0], "R5/R8 response cycle",
                      32'(cyc), 32'(exp_cyc_q[0]));
                void'(exp_data_q.pop_front());
                void'(exp_cyc_q.pop_front());
            end
        end
    end

    // drive one request, verify ready each cycle, return stall count
    task automatic issue(input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output int stalls);
        int b;
        bit exp_rdy;
        stalls = 0;
        b = int'(a[1:0]);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        #1;
        forever begin
            exp_rdy = (cyc + 1 - last_acc[b]) >= M;
            check(req_ready == exp_rdy, exp_rdy ? "R4 ready free bank" : "R3 stall busy bank",
                  32'(req_ready), 32'(exp_rdy));
            if (req_ready) break;
            stalls++;
            @(negedge clk);
            #1;
        end
        last_acc[b] = cyc + 1;
        if (wr) begin
            model[a] = d;
        end else begin
            exp_data_q.push_back(model[a]);
            exp_cyc_q.push_back(cyc + 1 + M);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_model();
        for (int b = 0; b < M; b++) last_acc[b] = -1000;
        exp_data_q.delete();
        exp_cyc_q.delete();
    endtask

    initial begin
        int st;
        int n0;
        reset_model();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 clean after reset",
              32'({req_ready, rsp_valid}), 32'h2);

        // vector table: mixed writes, same-bank collisions, reads
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][24], VEC[i][23:16], VEC[i][15:0], st);
        end
        idle(M + 3);

        // R6: writes alone raise no response
        n0 = rsp_count;
        for (int i = 0; i < 8; i++) issue(1'b1, AW'(8'h40 + i), DW'(16'hC000 + i), st);
        idle(M + 3);
        check(rsp_count == n0, "R6 writes silent", 32'(rsp_count), 32'(n0));

        // R8: consecutive read burst, no stall
        n0 = 0;
        for (int i = 0; i < 8; i++) begin
            issue(1'b0, AW'(8'h40 + i), '0, st);
            n0 += st;
        end
        check(n0 == 0, "R8 burst stall count", 32'(n0), 32'd0);
        idle(M + 3);

        // R9: read right behind a write to the same word
        issue(1'b1, 8'h22, 16'hBEEF, st);
        issue(1'b0, 8'h22, '0, st);
        check(st == M - 1, "R9 read waits for bank", 32'(st), 32'(M - 1));
        idle(M + 2);
        check(last_rsp == 16'hBEEF, "R9 new data returned", 32'(last_rsp), 32'hBEEF);

        // R1: reset with reads in flight drops them
        n0 = rsp_count;
        issue(1'b0, 8'h40, '0, st);
        issue(1'b0, 8'h41, '0, st);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        reset_model();
        @(negedge clk);
        rst = 1'b0;
        repeat (M + 3) @(negedge clk);
        check(rsp_count == n0, "R1 in-flight reads dropped", 32'(rsp_count), 32'(n0));

        // R7: every issued read answered
        check(exp_data_q.size() == 0, "R7 all reads answered",
              32'(exp_data_q.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule